// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a 16-bit DDR SDRAM from power-on to a state where it can be used. After reset it holds clock enable low and presents NOP. When it sees a start pulse, it raises clock enable and plays a fixed eight-step script on the command and address pins. The script contains two precharge-all commands, an extended mode load that turns the DLL on or off, a mode load that resets the DLL, two auto refreshes, and a final mode load that clears the DLL reset. Every mode load sets CAS latency 2 and burst length 2.

Each command is held for exactly one cycle. A parameterised run of NOP cycles separates consecutive commands. After the last command comes a longer parameterised wait, and then a sticky done flag goes high. From that point a downstream controller may drive the memory bus. The DLL bypass strap only changes the extended-mode word.

Top module: `ddr_powerup_seq`

## Requirements
- R1: While reset is high and afterwards until a start pulse, cke is 0, {ras_n,cas_n,we_n} is NOP, ba and row are zero and done is 0.
- R2: The command triple {ras_n,cas_n,we_n} uses NOP=3'b111, PRECHARGE=3'b010, AUTO REFRESH=3'b001 and LOAD MODE=3'b000. No other value appears.
- R3: With n counted from the first cycle after start is sampled, command step k (k = 0..7) appears at n = k*(GAP_CYCLES+1). The steps are, in order:
  - NOP with row 0 and cke rising to 1
  - PRECHARGE with row 0x400 and ba 0
  - LOAD MODE with ba 1 (the extended-mode word)
  - LOAD MODE with ba 0 and row 0x121
  - PRECHARGE with row 0x400
  - AUTO REFRESH with row 0
  - AUTO REFRESH with row 0
  - LOAD MODE with ba 0 and row 0x021
- R4: The extended-mode word in step 3 has row 0x000 when dll_bypass is 0 and row 0x001 when it is 1.
- R5: Every non-NOP command lasts one cycle and is followed by exactly GAP_CYCLES NOP cycles, with cke high and ba and row at zero.
- R6: After the last command, FINAL_CYCLES NOP cycles pass. done then rises at n = 7*(GAP_CYCLES+1)+1+FINAL_CYCLES, which is n = 136 with the default parameters.
- R7: Once high, done stays high and the outputs stay at NOP with cke high until reset.
- R8: A start pulse that arrives while the script runs, or after done, changes neither the timing nor the outputs.
- R9: A reset in the middle of the script returns the block to the R1 state. The next start replays the script from step 0.
- R10: ROW_W may be 12, 13 or 14. Any other value stops elaboration. Row bits at position 12 and above are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins the script |
| dll_bypass | input | 1 | Strap: 1 turns the device DLL off |
| cke | output | 1 | Clock enable to the memory |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| row | output | ROW_W | Row address bus |
| done | output | 1 | Script complete, sticky until reset |

## Verification
The assertions assume that dll_bypass is static for the whole script. They also assume that reset is a clean synchronous pulse, and that GAP_CYCLES is at least 1 so that commands can never touch each other. The bench changes the strap only while the block is idle or in reset. It sends start pulses at arbitrary cycles, including in the middle of the script and after done, which exercises the ignore rule without breaking the static-strap assumption. Reset is applied once in the middle of the script to test the restart path.

// File: rtl/ddr_init_pkg.sv
`timescale 1ns/1ps
package ddr_init_pkg;

   typedef enum logic [2:0] {
      CMD_LMR = 3'b000,
      CMD_REF = 3'b001,
      CMD_PRE = 3'b010,
      CMD_NOP = 3'b111
   } ddr_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_GAP,
      ST_FINAL,
      ST_DONE
   } seq_state_e;

   localparam int STEPS     = 8;
   localparam int STEP_W    = 3;
   localparam int MODE_W    = 12;
   localparam int BANK_W    = 2;

   localparam logic [MODE_W-1:0] W_ZERO    = 12'h000;
   localparam logic [MODE_W-1:0] W_PRE_ALL = 12'h400;
   localparam logic [MODE_W-1:0] W_DLL_OFF = 12'h001;
   localparam logic [MODE_W-1:0] W_MR_RST  = 12'h121;
   localparam logic [MODE_W-1:0] W_MR_RUN  = 12'h021;

endpackage

// File: rtl/ddr_init_script.sv
`timescale 1ns/1ps
module ddr_init_script
   import ddr_init_pkg::*;
#(
   parameter int ROW_W = 13
) (
   input  logic [STEP_W-1:0] step,
   input  logic              dll_bypass,
   output ddr_cmd_e          cmd,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  row
);

   logic [MODE_W-1:0] word;

   always_comb begin
      cmd  = CMD_NOP;
      ba   = '0;
      word = W_ZERO;
      unique case (step)
         3'd0: cmd = CMD_NOP;
         3'd1: begin cmd = CMD_PRE; word = W_PRE_ALL; end
         3'd2: begin
            cmd  = CMD_LMR;
            ba   = 2'b01;
            word = dll_bypass ? W_DLL_OFF : W_ZERO;
         end
         3'd3: begin cmd = CMD_LMR; word = W_MR_RST; end
         3'd4: begin cmd = CMD_PRE; word = W_PRE_ALL; end
         3'd5: cmd = CMD_REF;
         3'd6: cmd = CMD_REF;
         default: begin cmd = CMD_LMR; word = W_MR_RUN; end
      endcase
   end

   generate
      if (ROW_W > MODE_W) begin : g_wide
         assign row = {{(ROW_W-MODE_W){1'b0}}, word};
      end else begin : g_narrow
         assign row = word;
      end
   endgenerate

endmodule

// File: rtl/ddr_init_timer.sv
`timescale 1ns/1ps
module ddr_init_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)            cnt <= '0;
      else if (load)      cnt <= load_val;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/ddr_init_fsm.sv
`timescale 1ns/1ps
module ddr_init_fsm
   import ddr_init_pkg::*;
#(
   parameter int GAP_CYCLES   = 4,
   parameter int FINAL_CYCLES = 100,
   parameter int CNT_W        = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output seq_state_e       state,
   output logic [STEP_W-1:0] step
);

   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS-1);
   localparam logic [CNT_W-1:0]  GAP_LD    = CNT_W'(GAP_CYCLES-1);
   localparam logic [CNT_W-1:0]  FINAL_LD  = CNT_W'(FINAL_CYCLES-1);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         step  <= '0;
      end else begin
         unique case (state)
            ST_IDLE:  if (start) state <= ST_ISSUE;
            ST_ISSUE: state <= (step == LAST_STEP) ? ST_FINAL : ST_GAP;
            ST_GAP: if (tmr_expired) begin
               state <= ST_ISSUE;
               step  <= step + 1'b1;
            end
            ST_FINAL: if (tmr_expired) state <= ST_DONE;
            default:  state <= ST_DONE;
         endcase
      end
   end

   assign tmr_load = (state == ST_ISSUE);
   assign tmr_val  = (step == LAST_STEP) ? FINAL_LD : GAP_LD;

endmodule

// File: rtl/ddr_powerup_seq.sv
`timescale 1ns/1ps
module ddr_powerup_seq
   import ddr_init_pkg::*;
#(
   parameter int ROW_W        = 13,
   parameter int GAP_CYCLES   = 4,
   parameter int FINAL_CYCLES = 100
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             dll_bypass,
   output logic             cke,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic [1:0]       ba,
   output logic [ROW_W-1:0] row,
   output logic             done
);

   localparam int LONGEST = (GAP_CYCLES > FINAL_CYCLES) ? GAP_CYCLES : FINAL_CYCLES;
   localparam int CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);

   generate
      if (ROW_W < 12 || ROW_W > 14) begin : g_bad_row
         $error("ROW_W must be 12, 13 or 14");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("GAP_CYCLES must be at least 1");
      end
      if (FINAL_CYCLES < 1) begin : g_bad_final
         $error("FINAL_CYCLES must be at least 1");
      end
   endgenerate

   seq_state_e        state;
   logic [STEP_W-1:0] step;
   logic              tmr_load;
   logic              tmr_expired;
   logic [CNT_W-1:0]  tmr_val;
   ddr_cmd_e          scr_cmd;
   logic [BANK_W-1:0] scr_ba;
   logic [ROW_W-1:0]  scr_row;

   ddr_init_fsm #(
      .GAP_CYCLES  (GAP_CYCLES),
      .FINAL_CYCLES(FINAL_CYCLES),
      .CNT_W       (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .tmr_expired(tmr_expired),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .state      (state),
      .step       (step)
   );

   ddr_init_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .load    (tmr_load),
      .load_val(tmr_val),
      .expired (tmr_expired)
   );

   ddr_init_script #(.ROW_W(ROW_W)) u_script (
      .step      (step),
      .dll_bypass(dll_bypass),
      .cmd       (scr_cmd),
      .ba        (scr_ba),
      .row       (scr_row)
   );

   logic issuing;
   assign issuing = (state == ST_ISSUE);

   assign cke                 = (state != ST_IDLE);
   assign {ras_n, cas_n, we_n} = issuing ? scr_cmd : CMD_NOP;
   assign ba                  = issuing ? scr_ba  : '0;
   assign row                 = issuing ? scr_row : '0;
   assign done                = (state == ST_DONE);

endmodule

// File: rtl/ddr_init_chk.sv
`timescale 1ns/1ps
module ddr_init_chk #(
   parameter int ROW_W        = 13,
   parameter int GAP_CYCLES   = 4,
   parameter int FINAL_CYCLES = 100
) (
   input logic             clk,
   input logic             rst,
   input logic             cke,
   input logic             ras_n,
   input logic             cas_n,
   input logic             we_n,
   input logic [1:0]       ba,
   input logic [ROW_W-1:0] row,
   input logic             done
);

   localparam int RUN_W = $clog2(FINAL_CYCLES + GAP_CYCLES + 2) + 1;

   logic [2:0]       cmd;
   logic             is_nop;
   logic             seen_cmd;
   logic [RUN_W-1:0] nop_run;

   assign cmd    = {ras_n, cas_n, we_n};
   assign is_nop = (cmd == 3'b111);

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_cmd <= 1'b0;
         nop_run  <= '0;
      end else if (!is_nop) begin
         seen_cmd <= 1'b1;
         nop_run  <= '0;
      end else if (cke && nop_run != {RUN_W{1'b1}}) begin
         nop_run <= nop_run + 1'b1;
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !cke |-> (is_nop && ba == 2'b00 && row == '0 && !done));

   // R2
   legal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      cmd inside {3'b111, 3'b010, 3'b001, 3'b000});

   // R3
   precharge_all_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == 3'b010) |-> (row == ROW_W'(12'h400) && ba == 2'b00));

   // R5
   single_cycle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      !is_nop |=> is_nop);

   // R5
   nop_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
      is_nop |-> (ba == 2'b00 && row == '0));

   // R5
   gap_length_chk: assert property (@(posedge clk) disable iff (rst)
      (!is_nop && seen_cmd) |-> (nop_run == RUN_W'(GAP_CYCLES)));

   // R6
   final_wait_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> (nop_run == RUN_W'(FINAL_CYCLES)));

   // R7
   done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> (done && cke && is_nop));

endmodule

bind ddr_powerup_seq ddr_init_chk #(
   .ROW_W       (ROW_W),
   .GAP_CYCLES  (GAP_CYCLES),
   .FINAL_CYCLES(FINAL_CYCLES)
) u_chk (
   .clk  (clk),
   .rst  (rst),
   .cke  (cke),
   .ras_n(ras_n),
   .cas_n(cas_n),
   .we_n (we_n),
   .ba   (ba),
   .row  (row),
   .done (done)
);

// File: tb/test_ddr_powerup_seq.sv
`timescale 1ns/1ps
module test_ddr_powerup_seq;

   localparam int ROW_W   = 13;
   localparam int GAP     = 4;
   localparam int FINAL   = 100;
   localparam int PERIOD  = GAP + 1;
   localparam int DONE_AT = 7 * PERIOD + 1 + FINAL;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             start = 1'b0;
   logic             dll_bypass = 1'b0;
   logic             cke, ras_n, cas_n, we_n, done;
   logic [1:0]       ba;
   logic [ROW_W-1:0] row;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   ddr_powerup_seq #(
      .ROW_W(ROW_W), .GAP_CYCLES(GAP), .FINAL_CYCLES(FINAL)
   ) i_ddr_powerup_seq (
      .clk(clk), .rst(rst), .start(start), .dll_bypass(dll_bypass),
      .cke(cke), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .row(row), .done(done)
   );

   // packed view: cke, cmd[2:0], ba[1:0], row, done
   function automatic logic [ROW_W+6:0] pack(input logic k, input logic [2:0] c,
                                            input logic [1:0] b, input logic [ROW_W-1:0] r,
                                            input logic d);
      return {k, c, b, r, d};
   endfunction

   function automatic logic [ROW_W+6:0] observed();
      return pack(cke, {ras_n, cas_n, we_n}, ba, row, done);
   endfunction

   task automatic check(input string req, input logic [ROW_W+6:0] act,
                        input logic [ROW_W+6:0] exp, input int n);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s n=%0d actual=%h expected=%h", req, n, act, exp);
      end
   endtask

   // expected output n cycles after start was sampled
   task automatic expect_at(input int n, input logic dll, output logic [ROW_W+6:0] e,
                            output string req);
      int k;
      logic [2:0] c;
      logic [1:0] b;
      logic [11:0] w;
      c = 3'b111; b = 2'b00; w = 12'h000; req = "R5";
      if (n % PERIOD == 0 && n / PERIOD < 8) begin
         k = n / PERIOD;
         req = "R3";
         case (k)
            0: c = 3'b111;
            1: begin c = 3'b010; w = 12'h400; req = "R2"; end
            2: begin c = 3'b000; b = 2'b01; w = dll ? 12'h001 : 12'h000; req = "R4"; end
            3: begin c = 3'b000; w = 12'h121; end
            4: begin c = 3'b010; w = 12'h400; end
            5: c = 3'b001;
            6: c = 3'b001;
            default: begin c = 3'b000; w = 12'h021; end
         endcase
      end else if (n > 7 * PERIOD) begin
         req = "R6";
      end
      e = pack(1'b1, c, b, ROW_W'(w), (n >= DONE_AT));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; start = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", observed(), pack(1'b0, 3'b111, 2'b00, '0, 1'b0), -1);
      rst = 1'b0;
   endtask

   task automatic test_reset_idle();
      do_reset();
      repeat (20) @(negedge clk);
      check("R1", observed(), pack(1'b0, 3'b111, 2'b00, '0, 1'b0), -1);
   endtask

   // runs the script; with poke, extra start pulses arrive mid-run (R8)
   task automatic test_script(input logic dll, input bit poke, input int stop_at);
      logic [ROW_W+6:0] e;
      string req;
      do_reset();
      dll_bypass = dll;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n <= stop_at; n++) begin
         expect_at(n, dll, e, req);
         check(poke ? "R8" : req, observed(), e, n);
         start = poke && (n == 7 || n == 23 || n == DONE_AT + 1);
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic test_done_sticky();
      test_script(1'b0, 1'b0, DONE_AT);
      for (int i = 0; i < 30; i++) begin
         start = (i % 5 == 0);
         @(negedge clk);
         check("R7", observed(), pack(1'b1, 3'b111, 2'b00, '0, 1'b1), i);
      end
      start = 1'b0;
   endtask

   task automatic test_reset_midrun();
      test_script(1'b1, 1'b0, 17);
      rst = 1'b1;
      @(negedge clk);
      check("R9", observed(), pack(1'b0, 3'b111, 2'b00, '0, 1'b0), 0);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      check("R9", observed(), pack(1'b0, 3'b111, 2'b00, '0, 1'b0), 1);
      test_script(1'b1, 1'b0, 3 * PERIOD);
   endtask

   task automatic test_row_width();
      do_reset();
      checks++;
      if (ROW_W < 12 || ROW_W > 14) begin
         errors++;
         $display("FAIL R10 actual=%0d expected=12..14", ROW_W);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      test_reset_idle();
      test_script(1'b0, 1'b0, DONE_AT + 3);
      test_script(1'b1, 1'b0, DONE_AT + 3);
      test_script(1'b0, 1'b1, DONE_AT + 3);
      test_done_sticky();
      test_reset_midrun();
      test_row_width();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule